// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline. The pipeline has four execution units with unequal latencies: a single-stage integer unit, a four-stage pipelined FP adder, a seven-stage pipelined FP/integer multiplier and an unpipelined FP/integer divider. Every cycle the block receives at most one candidate instruction, given as a unit type, a destination register and two source registers. In the same cycle it answers with either issue or stall. If it stalls, it also reports which hazard classes caused the stall.

To decide, the block keeps three records of the work already in flight. The first is a shift register of reserved write-back slots. The second is a positional tag pipeline for each pipelined FP unit. The third is a countdown for the divider. Across these records it checks four hazards: divider occupancy, double booking of the single register write port, reads of results that cannot yet be forwarded, and writes that would overtake an older write to the same register. The requester holds a stalled request unchanged and presents it again in the next cycle.

Top module: `issue_hazard_check`

## Requirements
- R1: While `req_valid` is high, exactly one of `issue` and `stall` is high in the same cycle. While `req_valid` is low, both are low.
- R2: After reset, no operation counts as in flight. The first request after reset issues at once, whatever was in flight before the reset.
- R3: An operation issued in cycle t writes back in cycle t+W, where W is 3 for integer, 6 for add, 9 for multiply and 26 for divide (execute stages plus two). A request whose write-back cycle is already reserved stalls with the port cause.
- R4: A divide issued in cycle t makes any divide request stall with the busy cause in cycles t+1 through t+24. A divide can issue again from cycle t+25.
- R5: A request stalls with the RAW cause when one of its sources equals the destination of an op that still has execute cycles after the current one. For an op issued in cycle t, this covers cycles t+1..t+3 for add, t+1..t+6 for multiply and t+1..t+23 for divide. Integer results never cause a RAW stall.
- R6: A request stalls with the WAW cause when its destination equals that of an op still inside the add stages (t+1..t+4), the multiply stages (t+1..t+7) or the divider (t+1..t+24). Integer ops are not considered.
- R7: `stall_cause` is encoded as bit 3 busy, bit 2 port, bit 1 RAW, bit 0 WAW. Several bits may be set together. It is zero whenever `issue` is high or `req_valid` is low.
- R8: A cycle with `req_valid` low reserves nothing and tracks nothing, even when the other request fields name a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A candidate instruction is present |
| req_unit | input | 2 | Unit type: 0 integer, 1 add, 2 multiply, 3 divide |
| req_dst | input | REG_W | Destination register |
| req_src1 | input | REG_W | First source register |
| req_src2 | input | REG_W | Second source register |
| issue | output | 1 | The request issues this cycle |
| stall | output | 1 | The request must be held and retried |
| stall_cause | output | 4 | Hazard classes behind a stall (R7 encoding) |

## Verification
The hardest situation to reach is a set of hazards that overlap at one exact cycle, long after the operation that caused them. One example is an integer write-back that lands on the same cycle as a divide issued 23 cycles earlier, while that divide still blocks the same destination. The stimulus gets there by presenting a request and holding it for many consecutive cycles. Each cycle's expected cause vector is computed from the issue cycle of the older operation, so every window edge is checked: the cycle where RAW clears, where WAW clears, where busy clears, and the single cycle where the port collides.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_FDIV = 2'd3
    } unit_e;

    // bit 3 busy, bit 2 port, bit 1 raw, bit 0 waw
    typedef struct packed {
        logic busy;
        logic port;
        logic raw;
        logic waw;
    } cause_t;

endpackage

// File: rtl/ihc_stage_tags.sv
// Positional destination tags for one fully pipelined unit.
// Slot i holds the op that is in execute stage i+1 during this cycle.
module ihc_stage_tags #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [REG_W-1:0] push_dst_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [REG_W-1:0] src1_i,
    input  logic [REG_W-1:0] src2_i,
    output logic             raw_o,
    output logic             waw_o
);

    // Only the last slot has its result ready for forwarding.
    localparam logic [DEPTH-1:0] RAW_MASK = {1'b0, {(DEPTH-1){1'b1}}};

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][REG_W-1:0] tag;
    } tags_t;

    tags_t st_d, st_q;
    logic [DEPTH-1:0] dst_hit;
    logic [DEPTH-1:0] src_hit;

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[DEPTH-2:0], push_i};
        st_d.tag = {st_q.tag[DEPTH-2:0], push_dst_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign dst_hit[i] = st_q.vld[i] && (st_q.tag[i] == dst_i);
        assign src_hit[i] = st_q.vld[i] &&
                            ((st_q.tag[i] == src1_i) || (st_q.tag[i] == src2_i));
    end

    assign raw_o = |(src_hit & RAW_MASK);
    assign waw_o = |dst_hit;

    // R6: a tag pushed last cycle is visible against the same destination
    a_r6_push_seen: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (st_q.vld[0] && (st_q.tag[0] == $past(push_dst_i))));

endmodule

// File: rtl/ihc_div_track.sv
// Occupancy, destination and progress of the single unpipelined divider.
module ihc_div_track #(
    parameter int STAGES = 24,
    parameter int II     = 25,
    parameter int REG_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [REG_W-1:0] issue_dst_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [REG_W-1:0] src1_i,
    input  logic [REG_W-1:0] src2_i,
    output logic             busy_o,
    output logic             raw_o,
    output logic             waw_o
);

    localparam int CNT_W = $clog2(II);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(II - 1);
    // Counter value during the last execute cycle.
    localparam logic [CNT_W-1:0] LAST_EX = CNT_W'(II - STAGES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REG_W-1:0] tag;
    } div_t;

    div_t st_d, st_q;
    logic in_ex;
    logic src_eq;

    always_comb begin
        st_d = st_q;
        if (issue_i) begin
            st_d.cnt = RELOAD;
            st_d.tag = issue_dst_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ex  = (st_q.cnt >= LAST_EX);
    assign src_eq = (st_q.tag == src1_i) || (st_q.tag == src2_i);
    assign busy_o = (st_q.cnt != '0);
    assign raw_o  = (st_q.cnt > LAST_EX) && src_eq;
    assign waw_o  = in_ex && (st_q.tag == dst_i);

    // R4: a divide is never accepted while the previous one occupies the unit
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> (st_q.cnt == '0));

endmodule

// File: rtl/ihc_wb_reserve.sv
// Write-port reservation shift register. Bit k set means the write port is
// taken k cycles from now; bit 0 is the current write-back cycle.
module ihc_wb_reserve #(
    parameter int RES_W = 27,
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             taken_o
);

    typedef struct packed {
        logic [RES_W-1:0] slots;
    } res_t;

    res_t st_d, st_q;

    always_comb begin
        st_d.slots = st_q.slots >> 1;
        if (set_i && (pos_i != '0) && (int'(pos_i) < RES_W)) begin
            st_d.slots[pos_i - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o = (int'(pos_i) < RES_W) ? st_q.slots[pos_i] : 1'b0;

    // R3: a reservation is only made in a free slot
    a_r3_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> !st_q.slots[pos_i]);

    // R3: reservation positions stay inside the register
    a_r3_pos_legal: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> ((pos_i != '0) && (int'(pos_i) < RES_W)));

endmodule

// File: rtl/issue_hazard_check.sv
module issue_hazard_check
    import ihc_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int INT_STAGES = 1,
    parameter int ADD_STAGES = 4,
    parameter int MUL_STAGES = 7,
    parameter int DIV_STAGES = 24,
    parameter int DIV_II     = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_unit,
    input  logic [REG_W-1:0] req_dst,
    input  logic [REG_W-1:0] req_src1,
    input  logic [REG_W-1:0] req_src2,
    output logic             issue,
    output logic             stall,
    output logic [3:0]       stall_cause
);

    // Issue-to-write-back distance: execute stages, then memory, then write-back.
    localparam int W_INT = INT_STAGES + 2;
    localparam int W_ADD = ADD_STAGES + 2;
    localparam int W_MUL = MUL_STAGES + 2;
    localparam int W_DIV = DIV_STAGES + 2;
    localparam int RES_W = W_DIV + 1;
    localparam int POS_W = $clog2(RES_W);

    unit_e            unit_w;
    logic [POS_W-1:0] wb_pos;
    cause_t           cause;
    logic             any_hazard;
    logic             issue_w;

    logic add_raw, add_waw;
    logic mul_raw, mul_waw;
    logic div_busy, div_raw, div_waw;
    logic port_taken;

    assign unit_w = unit_e'(req_unit);

    always_comb begin
        case (unit_w)
            UNIT_FADD: wb_pos = POS_W'(W_ADD);
            UNIT_FMUL: wb_pos = POS_W'(W_MUL);
            UNIT_FDIV: wb_pos = POS_W'(W_DIV);
            default:   wb_pos = POS_W'(W_INT);
        endcase
    end

    always_comb begin
        cause = '0;
        if (req_valid) begin
            cause.busy = (unit_w == UNIT_FDIV) && div_busy;
            cause.port = port_taken;
            cause.raw  = add_raw | mul_raw | div_raw;
            cause.waw  = add_waw | mul_waw | div_waw;
        end
        any_hazard = |cause;
        issue_w    = req_valid && !any_hazard;
    end

    assign issue       = issue_w;
    assign stall       = req_valid && any_hazard;
    assign stall_cause = cause;

    ihc_stage_tags #(.DEPTH(ADD_STAGES), .REG_W(REG_W)) u_add_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (issue_w && (unit_w == UNIT_FADD)),
        .push_dst_i (req_dst),
        .dst_i      (req_dst),
        .src1_i     (req_src1),
        .src2_i     (req_src2),
        .raw_o      (add_raw),
        .waw_o      (add_waw)
    );

    ihc_stage_tags #(.DEPTH(MUL_STAGES), .REG_W(REG_W)) u_mul_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (issue_w && (unit_w == UNIT_FMUL)),
        .push_dst_i (req_dst),
        .dst_i      (req_dst),
        .src1_i     (req_src1),
        .src2_i     (req_src2),
        .raw_o      (mul_raw),
        .waw_o      (mul_waw)
    );

    ihc_div_track #(.STAGES(DIV_STAGES), .II(DIV_II), .REG_W(REG_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue_w && (unit_w == UNIT_FDIV)),
        .issue_dst_i (req_dst),
        .dst_i       (req_dst),
        .src1_i      (req_src1),
        .src2_i      (req_src2),
        .busy_o      (div_busy),
        .raw_o       (div_raw),
        .waw_o       (div_waw)
    );

    ihc_wb_reserve #(.RES_W(RES_W), .POS_W(POS_W)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (issue_w),
        .pos_i   (wb_pos),
        .taken_o (port_taken)
    );

    // R1: a valid request gets exactly one answer
    a_r1_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (issue != stall));

    // R1: no answer without a request
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(issue || stall));

    // R7: an issuing cycle reports no cause
    a_r7_clean_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (stall_cause == 4'b0000));

    // R4: two divides never issue back to back
    a_r4_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (req_unit == UNIT_FDIV)) |=> !(issue && (req_unit == UNIT_FDIV)));

    // R6: a non-integer writer blocks the same destination in the next cycle
    a_r6_waw_next: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (req_unit != UNIT_INT)) |=> !(issue && (req_dst == $past(req_dst))));

    // R5: a multi-stage result cannot be read in the following cycle
    a_r5_raw_next: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ((req_unit == UNIT_FADD) || (req_unit == UNIT_FMUL))) |=>
        !(issue && ((req_src1 == $past(req_dst)) || (req_src2 == $past(req_dst)))));

endmodule

// File: tb/issue_hazard_check_tb.sv
module issue_hazard_check_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    typedef struct packed {
        logic       v;
        logic [1:0] u;
        logic [4:0] d;
        logic [4:0] a;
        logic [4:0] b;
        logic       iss;
        logic [3:0] c;
    } vec_t;

    // unit: 0 int, 1 add, 2 mul, 3 div; cause: busy,port,raw,waw
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 5'd1,  5'd2,  5'd3,  1'b1, 4'h0}, // 0  add r1 issues
        '{1'b1, 2'd0, 5'd4,  5'd1,  5'd5,  1'b0, 4'h2}, // 1  R5 raw on r1
        '{1'b1, 2'd0, 5'd4,  5'd1,  5'd5,  1'b0, 4'h2}, // 2  R5
        '{1'b1, 2'd0, 5'd4,  5'd1,  5'd5,  1'b0, 4'h6}, // 3  R5 + R3 port at add write-back
        '{1'b1, 2'd0, 5'd4,  5'd1,  5'd5,  1'b1, 4'h0}, // 4  R5 window over
        '{1'b1, 2'd2, 5'd9,  5'd10, 5'd11, 1'b1, 4'h0}, // 5  mul r9 issues
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h3}, // 6  R5 + R6
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h3}, // 7
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h3}, // 8
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h3}, // 9
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h3}, // 10
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h7}, // 11 R3 port with mul write-back
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b0, 4'h1}, // 12 R6 only (M7)
        '{1'b1, 2'd0, 5'd9,  5'd9,  5'd13, 1'b1, 4'h0}, // 13 mul gone
        '{1'b1, 2'd1, 5'd20, 5'd21, 5'd22, 1'b1, 4'h0}, // 14 add r20
        '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0, 4'h0}, // 15 idle
        '{1'b0, 2'd0, 5'd0,  5'd0,  5'd0,  1'b0, 4'h0}, // 16 idle
        '{1'b1, 2'd0, 5'd23, 5'd24, 5'd25, 1'b0, 4'h4}, // 17 R3 same write-back cycle
        '{1'b1, 2'd0, 5'd23, 5'd24, 5'd25, 1'b1, 4'h0}, // 18 R3 next slot free
        '{1'b0, 2'd3, 5'd2,  5'd2,  5'd2,  1'b0, 4'h0}, // 19 R8 invalid divide
        '{1'b1, 2'd3, 5'd3,  5'd4,  5'd5,  1'b1, 4'h0}, // 20 R8 divide still free
        '{1'b1, 2'd3, 5'd6,  5'd3,  5'd7,  1'b0, 4'hA}, // 21 R4 busy + R5 raw
        '{1'b1, 2'd1, 5'd3,  5'd8,  5'd8,  1'b0, 4'h1}  // 22 R6 against divider
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_unit = '0;
    logic [4:0] req_dst = '0;
    logic [4:0] req_src1 = '0;
    logic [4:0] req_src2 = '0;
    logic       issue;
    logic       stall;
    logic [3:0] stall_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_hazard_check dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_unit    (req_unit),
        .req_dst     (req_dst),
        .req_src1    (req_src1),
        .req_src2    (req_src2),
        .issue       (issue),
        .stall       (stall),
        .stall_cause (stall_cause)
    );

    function automatic string tag_of(logic [3:0] c);
        string s;
        s = "";
        if (c == 4'h0) return "R1";
        if (c[3]) s = {s, "R4 "};
        if (c[2]) s = {s, "R3 "};
        if (c[1]) s = {s, "R5 "};
        if (c[0]) s = {s, "R6 "};
        return {s, "R7"};
    endfunction

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_unit  = '0;
        req_dst   = '0;
        req_src1  = '0;
        req_src2  = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic drive(logic v, logic [1:0] u, logic [4:0] d, logic [4:0] a, logic [4:0] b);
        @(posedge clk);
        #1;
        req_valid = v;
        req_unit  = u;
        req_dst   = d;
        req_src1  = a;
        req_src2  = b;
    endtask

    task automatic expect_out(string tag, logic e_iss, logic [3:0] e_cause);
        logic e_stall;
        @(negedge clk);
        e_stall = req_valid && !e_iss;
        checks++;
        if (issue !== e_iss || stall !== e_stall || stall_cause !== e_cause) begin
            errors++;
            $display("FAIL %s: issue=%0b stall=%0b cause=%h expected issue=%0b stall=%0b cause=%h",
                     tag, issue, stall, stall_cause, e_iss, e_stall, e_cause);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: idle after reset, no answer
        expect_out("R2", 1'b0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v, VECS[i].u, VECS[i].d, VECS[i].a, VECS[i].b);
            expect_out(tag_of(VECS[i].c), VECS[i].iss, VECS[i].c);
        end

        // R2: reset while a divide is in flight, next divide issues at once
        do_reset();
        drive(1'b1, 2'd3, 5'd28, 5'd29, 5'd30);
        expect_out("R2", 1'b1, 4'h0);

        // R4/R5: second divide reads r28, held until the unit frees
        for (int k = 1; k <= 25; k++) begin
            logic [3:0] c;
            c = {(k <= 24), 1'b0, (k <= 23), 1'b0};
            drive(1'b1, 2'd3, 5'd31, 5'd28, 5'd28);
            expect_out((k == 25) ? "R4" : tag_of(c), (k == 25), c);
        end

        // R6/R3: integer write to r31 while the divide writing r31 runs
        for (int k = 1; k <= 25; k++) begin
            logic [3:0] c;
            c = {1'b0, (k == 23), 1'b0, (k <= 24)};
            drive(1'b1, 2'd0, 5'd31, 5'd1, 5'd2);
            expect_out((k == 25) ? "R6" : tag_of(c), (k == 25), c);
        end

        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        expect_out("R1", 1'b0, 4'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule